// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry Flag

This block is the shift and rotate datapath of a small 32-bit integer core. Each cycle it receives a 16-bit operation word together with the current value of the destination register and of a second source register, and returns the new destination value combinationally. A single-bit carry-style flag (called T here) is held inside the block. The single-bit rotates and shifts read and write T, and they update it on the rising clock edge.

The unit covers four groups of operations:
- single-bit rotates, either through T or around the word;
- single-bit arithmetic and logical shifts;
- fixed logical shifts by 2, 8 and 16 places;
- two dynamic shifts whose direction and distance come from the second source.

For a dynamic shift, a non-negative source shifts left by its low five bits. A negative source shifts right by the low five bits of its negation, and when those bits are zero the shift covers the full width. The register file sits outside the block. The core writes `rd_out` back when `op_en` is high and `bad_op` is low.

Top module: `shift_rot_unit`

## Requirements
- R1: Operation word 0x4n24 (any n) rotates left through T: the result is the source shifted left by one with the old T in bit 0, and T takes the old bit 31 at the next clock edge.
- R2: Operation word 0x4n25 rotates right through T: the result is the source shifted right by one with the old T in bit 31, and T takes the old bit 0 at the next edge.
- R3: Operation word 0x4n04 rotates left by one, so that the old bit 31 goes to both bit 0 and T. Operation word 0x4n05 rotates right by one, so that the old bit 0 goes to both bit 31 and T.
- R4: Operation words 0x4n00 and 0x4n20 shift left by one and load T with the old bit 31. Operation word 0x4n21 shifts right arithmetically, operation word 0x4n01 shifts right logically, and both load T with the old bit 0.
- R5: Operation words 0x4n08, 0x4n18 and 0x4n28 shift left logically by 2, 8 and 16. Operation words 0x4n09, 0x4n19 and 0x4n29 shift right logically by the same amounts. None of them changes T.
- R6: Operation word 0x4nmC is an arithmetic dynamic shift:
  - when the source is non-negative, shift left by source[4:0];
  - when the source is negative, shift right arithmetically by (−source)[4:0];
  - when the source is negative and source[4:0] is zero, shift right arithmetically by 31.
- R7: Operation word 0x4nmD is a logical dynamic shift with the same direction rule as R6, with zero fill on right shifts. When the source is negative and source[4:0] is zero, the result is 0.
- R8: Any other operation word, when `op_en` is high, raises `bad_op`, returns the destination unchanged and leaves T unchanged.
- R9: T resets to 0. It changes only on a clock edge with `op_en` high and one of the single-bit operations of R1–R4. The dynamic and fixed shifts never change it, and nothing changes it while `op_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Operation valid this cycle |
| op_word | input | 16 | Operation word |
| rd_in | input | 32 | Current destination register value |
| rs_in | input | 32 | Second source value (dynamic shift control) |
| rd_out | output | 32 | New destination value |
| t_flag | output | 1 | Registered T flag |
| bad_op | output | 1 | Unrecognised operation word while op_en is high |

## Verification
The bench builds the unit with its default width of 32, so the shift control is five bits wide. At this width the full-width negative case of the dynamic shifts occurs for the source values −32, −64 and any other negative value whose low five bits are zero. Directed cases cover these values, the largest left shift (31), a shift by zero, and −1. The remaining cases use random operation words, which include illegal ones. The bench gets T to 1 or 0 only through earlier single-bit operations, so a checked chain of T values shows how each operation passes T through to later ones.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_en,
  input  logic [15:0]  op_word,
  input  logic [W-1:0] rd_in,
  input  logic [W-1:0] rs_in,
  output logic [W-1:0] rd_out,
  output logic         t_flag,
  output logic         bad_op
);
  localparam int AW = $clog2(W);

  typedef enum logic [4:0] {
    K_NONE, K_ROTCL, K_ROTCR, K_ROTL, K_ROTR, K_SHLL, K_SHAR, K_SHLR,
    K_SL2, K_SR2, K_SL8, K_SR8, K_SL16, K_SR16, K_DYNA, K_DYNL
  } kind_t;

  kind_t kind;
  logic t_q;
  logic single;

  always_comb begin
    kind = K_NONE;
    if (op_word[15:12] == 4'b0100) begin
      if (op_word[3:0] == 4'hC)      kind = K_DYNA;
      else if (op_word[3:0] == 4'hD) kind = K_DYNL;
      else begin
        case (op_word[7:0])
          8'h24: kind = K_ROTCL;
          8'h25: kind = K_ROTCR;
          8'h04: kind = K_ROTL;
          8'h05: kind = K_ROTR;
          8'h00, 8'h20: kind = K_SHLL;
          8'h21: kind = K_SHAR;
          8'h01: kind = K_SHLR;
          8'h08: kind = K_SL2;
          8'h09: kind = K_SR2;
          8'h18: kind = K_SL8;
          8'h19: kind = K_SR8;
          8'h28: kind = K_SL16;
          8'h29: kind = K_SR16;
          default: kind = K_NONE;
        endcase
      end
    end
  end

  logic          neg_ctl;
  logic [W-1:0]  neg_rs;
  logic [AW-1:0] left_amt, right_amt;
  logic          full_w;
  logic [W-1:0]  dyn_a, dyn_l;

  assign neg_ctl   = rs_in[W-1];
  assign neg_rs    = -rs_in;
  assign left_amt  = rs_in[AW-1:0];
  assign right_amt = neg_rs[AW-1:0];
  assign full_w    = (rs_in[AW-1:0] == '0);

  always_comb begin
    if (!neg_ctl) begin
      dyn_a = rd_in << left_amt;
      dyn_l = rd_in << left_amt;
    end else if (full_w) begin
      dyn_a = {W{rd_in[W-1]}};
      dyn_l = '0;
    end else begin
      dyn_a = $signed(rd_in) >>> right_amt;
      dyn_l = rd_in >> right_amt;
    end
  end

  logic [W-1:0] res;
  logic         t_nxt;

  always_comb begin
    res    = rd_in;
    t_nxt  = t_q;
    single = 1'b0;
    case (kind)
      K_ROTCL: begin res = {rd_in[W-2:0], t_q};       t_nxt = rd_in[W-1]; single = 1'b1; end
      K_ROTCR: begin res = {t_q, rd_in[W-1:1]};       t_nxt = rd_in[0];   single = 1'b1; end
      K_ROTL:  begin res = {rd_in[W-2:0], rd_in[W-1]}; t_nxt = rd_in[W-1]; single = 1'b1; end
      K_ROTR:  begin res = {rd_in[0], rd_in[W-1:1]};  t_nxt = rd_in[0];   single = 1'b1; end
      K_SHLL:  begin res = {rd_in[W-2:0], 1'b0};      t_nxt = rd_in[W-1]; single = 1'b1; end
      K_SHAR:  begin res = {rd_in[W-1], rd_in[W-1:1]}; t_nxt = rd_in[0];  single = 1'b1; end
      K_SHLR:  begin res = {1'b0, rd_in[W-1:1]};      t_nxt = rd_in[0];   single = 1'b1; end
      K_SL2:   res = rd_in << 2;
      K_SR2:   res = rd_in >> 2;
      K_SL8:   res = rd_in << 8;
      K_SR8:   res = rd_in >> 8;
      K_SL16:  res = rd_in << 16;
      K_SR16:  res = rd_in >> 16;
      K_DYNA:  res = dyn_a;
      K_DYNL:  res = dyn_l;
      default: res = rd_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               t_q <= 1'b0;
    else if (op_en && single) t_q <= t_nxt;
  end

  assign rd_out = res;
  assign t_flag = t_q;
  assign bad_op = op_en && (kind == K_NONE);

  // R9: T holds unless a single-bit operation is issued
  a_r9_t_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_en && single) |=> $stable(t_flag));

  // R8: an illegal word passes the destination through and holds T
  a_r8_bad_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> (rd_out == rd_in));
  a_r8_bad_t_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> $stable(t_flag));

  // R3: rotate left carries the top bit into T and into bit 0
  a_r3_rotl_t: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_word[15:12] == 4'h4 && op_word[7:0] == 8'h04)
      |=> (t_flag == $past(rd_in[W-1])));

  // R2: rotate right through T loads T from bit 0
  a_r2_rotcr_t: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_word[15:12] == 4'h4 && op_word[7:0] == 8'h25)
      |=> (t_flag == $past(rd_in[0])));

  // R7: logical dynamic shift by full width yields zero
  a_r7_full_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_word[15:12] == 4'h4 && op_word[3:0] == 4'hD &&
     rs_in[W-1] && rs_in[AW-1:0] == '0) |-> (rd_out == '0));

  // R5: fixed left shift by 2 clears the low two bits
  a_r5_sl2_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_word[15:12] == 4'h4 && op_word[7:0] == 8'h08)
      |-> (rd_out[1:0] == 2'b00));
endmodule

// File: tb/tb_shift_rot_unit.sv
module tb_shift_rot_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_en = 1'b0;
  logic [15:0] op_word = 16'h0009;
  logic [31:0] rd_in = '0, rs_in = '0;
  logic [31:0] rd_out;
  logic        t_flag, bad_op;

  int checks = 0, errors = 0;
  logic tm = 1'b0;
  bit done = 0;

  shift_rot_unit #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_word(op_word),
    .rd_in(rd_in), .rs_in(rs_in), .rd_out(rd_out), .t_flag(t_flag), .bad_op(bad_op)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] shr_n(logic [31:0] v, int n, logic arith);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) r = {arith ? r[31] : 1'b0, r[31:1]};
    return r;
  endfunction

  function automatic logic [31:0] shl_n(logic [31:0] v, int n);
    logic [31:0] r = v;
    for (int i = 0; i < n; i++) r = {r[30:0], 1'b0};
    return r;
  endfunction

  // returns {bad, t_next, result}
  function automatic logic [33:0] model(logic [15:0] w, logic [31:0] a, logic [31:0] s, logic t);
    logic [31:0] q = a;
    logic nt = t;
    logic bad = 1'b0;
    int amt;
    if (w[15:12] != 4'h4) bad = 1'b1;
    else if (w[3:0] == 4'hC || w[3:0] == 4'hD) begin
      if (!s[31]) q = shl_n(a, int'(s[4:0]));
      else begin
        amt = int'(5'((~s) + 32'd1));
        if (amt == 0) q = (w[3:0] == 4'hC) ? shr_n(a, 31, 1'b1) : 32'd0;
        else q = shr_n(a, amt, w[3:0] == 4'hC);
      end
    end else begin
      case (w[7:0])
        8'h24: begin q = {a[30:0], t}; nt = a[31]; end
        8'h25: begin q = {t, a[31:1]}; nt = a[0]; end
        8'h04: begin q = {a[30:0], a[31]}; nt = a[31]; end
        8'h05: begin q = {a[0], a[31:1]}; nt = a[0]; end
        8'h00, 8'h20: begin q = shl_n(a, 1); nt = a[31]; end
        8'h21: begin q = shr_n(a, 1, 1'b1); nt = a[0]; end
        8'h01: begin q = shr_n(a, 1, 1'b0); nt = a[0]; end
        8'h08: q = shl_n(a, 2);
        8'h18: q = shl_n(a, 8);
        8'h28: q = shl_n(a, 16);
        8'h09: q = shr_n(a, 2, 1'b0);
        8'h19: q = shr_n(a, 8, 1'b0);
        8'h29: q = shr_n(a, 16, 1'b0);
        default: bad = 1'b1;
      endcase
    end
    return {bad, nt, q};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(string tag, logic [15:0] w, logic [31:0] a, logic [31:0] s);
    logic [33:0] e;
    @(negedge clk);
    op_en = 1'b1; op_word = w; rd_in = a; rs_in = s;
    e = model(w, a, s, tm);
    #1;
    chk(tag, "result", rd_out, e[31:0]);
    chk(tag, "bad_op", {31'd0, bad_op}, {31'd0, e[33]});
    @(posedge clk); #1;
    tm = e[33] ? tm : e[32];
    chk(tag, "T", {31'd0, t_flag}, {31'd0, tm});
    op_en = 1'b0;
  endtask

  function automatic string tag_of(logic [15:0] w);
    if (w[15:12] != 4'h4) return "R8";
    if (w[3:0] == 4'hC) return "R6";
    if (w[3:0] == 4'hD) return "R7";
    case (w[7:0])
      8'h24: return "R1";
      8'h25: return "R2";
      8'h04, 8'h05: return "R3";
      8'h00, 8'h20, 8'h21, 8'h01: return "R4";
      8'h08, 8'h18, 8'h28, 8'h09, 8'h19, 8'h29: return "R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    logic [7:0] lows [16] = '{8'h24, 8'h25, 8'h04, 8'h05, 8'h00, 8'h20, 8'h21, 8'h01,
                              8'h08, 8'h18, 8'h28, 8'h09, 8'h19, 8'h29, 8'h3C, 8'h5D};
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset T", {31'd0, t_flag}, 32'd0);
    rst_n = 1'b1;

    run("R1", 16'h4324, 32'h8000_0001, 32'h0);
    run("R1", 16'h4324, 32'h0000_0000, 32'h0);
    run("R2", 16'h4125, 32'h0000_0003, 32'h0);
    run("R2", 16'h4125, 32'h0000_0000, 32'h0);
    run("R3", 16'h4004, 32'h8000_0000, 32'h0);
    run("R3", 16'h4005, 32'h0000_0002, 32'h0);
    run("R4", 16'h4021, 32'h8000_0001, 32'h0);
    run("R4", 16'h4001, 32'h8000_0000, 32'h0);
    run("R4", 16'h4020, 32'hC000_0000, 32'h0);
    run("R5", 16'h4028, 32'h1234_5678, 32'h0);
    run("R5", 16'h4019, 32'hF234_5678, 32'h0);
    run("R6", 16'h412C, 32'h8000_00F0, 32'hFFFF_FFE0);
    run("R6", 16'h412C, 32'h4000_00F0, 32'hFFFF_FFC0);
    run("R6", 16'h412C, 32'h0000_0001, 32'd31);
    run("R6", 16'h412C, 32'hA5A5_A5A5, 32'd0);
    run("R6", 16'h412C, 32'h8000_0000, 32'hFFFF_FFFF);
    run("R7", 16'h412D, 32'hFFFF_FFFF, 32'hFFFF_FFE0);
    run("R7", 16'h412D, 32'h8000_0000, 32'hFFFF_FFFF);
    run("R7", 16'h412D, 32'h0000_0003, 32'd33);
    run("R8", 16'h4010, 32'hDEAD_BEEF, 32'h0);
    run("R8", 16'h0009, 32'h1111_2222, 32'h0);

    @(negedge clk);
    op_en = 1'b0; op_word = 16'h4024; rd_in = {~tm, 31'd0};
    @(posedge clk); #1;
    chk("R9", "T with op_en low", {31'd0, t_flag}, {31'd0, tm});

    for (int i = 0; i < 600; i++) begin
      w = $urandom;
      if ($urandom_range(0, 4) != 0) w = {4'h4, w[11:8], lows[$urandom_range(0, 15)]};
      run(tag_of(w), w, $urandom, ($urandom_range(0, 3) == 0) ? {27'h7FF_FFFF, 5'd0} : $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule